// File: doc/BRIEF.md
# H-Bridge Fixed Off-Time Current Chopper

This block regulates load current in an H-bridge. It turns a drive command into gate enables for the high-side and low-side switches of both half-bridges. The drive command is an enable bit and a direction bit. Each half-bridge has a current-trip comparator flag. When a trip is seen on a half-bridge whose regulation is enabled, the block leaves the commanded drive. It switches both high-side devices on, which lets the current recirculate and decay slowly. It holds that state for an off time chosen by a 2-bit register input.

When the off time ends, the block checks the trip flag again. If the current is still above the trip level, another off period begins. Otherwise the outputs return to the drive command. A blanking interval then runs, during which the trip flag is ignored so that switching transients cannot end the drive early.

All timing is counted in ticks of 1 µs, derived from the system clock by a prescaler. The prescaler restarts at the start of each interval, so every interval lasts a whole number of microseconds measured in clock cycles. While an off period runs, the drive command may ask for the opposite direction to speed up the decay. A status output stays high for the whole of every off period.

Top module: `trip_chopper`

## Requirements
- R1: Outside an off period the gates follow the command. With the enable low, all four gates are off. With direction 0, hsOn=2'b01 and lsOn=2'b10 (bit 0 is half-bridge 1). With direction 1, hsOn=2'b10 and lsOn=2'b01.
- R2: Each raw trip flag passes through two synchronizing flops. A qualified trip during drive raises offActive on the third rising edge after the raw flag rises.
- R3: During an off period with no reversal command, hsOn=2'b11 and lsOn=2'b00. This holds even when the drive enable is low.
- R4: The off-time select code sets the length of an off period to (code+1)×20 µs: 00=20, 01=40, 10=60, 11=80. That is (code+1)×20×TICK_DIV clock cycles.
- R5: After an off period ends without a trip, a blanking interval of 4 µs (4×TICK_DIV cycles) follows. The same interval follows reset. Trip flags during blanking start no off period.
- R6: If a qualified trip is present when an off period ends, a new off period starts at once. offActive stays high without a gap.
- R7: The length of an off period is taken from the select input when that period starts. A change of the select during the period applies only to the next period.
- R8: The regulation-disable field works as follows: 00 regulates both outputs; 01 ignores the trip flag of half-bridge 1; 10 ignores that of half-bridge 2; 11 ignores both.
- R9: During an off period, an enabled command whose direction differs from the direction held at entry drives the R1 pattern for the new direction. The off timer and offActive are not disturbed.
- R10: After reset, offActive is low, the block is in blanking, and the gates follow the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| driveEn | input | 1 | Drive command enable |
| driveDir | input | 1 | Drive direction, 0 forward, 1 reverse |
| tripRaw | input | 2 | Asynchronous trip comparator flags, one per half-bridge |
| offSel | input | 2 | Off-time select code |
| regDis | input | 2 | Per-half-bridge regulation disable |
| hsOn | output | 2 | High-side gate enables |
| lsOn | output | 2 | Low-side gate enables |
| offActive | output | 1 | High for the whole of each off period |

## Verification
The chopper is driven through these patterns:
- a trip inside the blanking window, which must be ignored;
- a short trip, which must give exactly one off period;
- a trip held across the end of a period, which must chain a second period of the same length;
- a select change in the middle of a period, which must alter only the following period.

Each regulation-disable code is paired with trips on one leg and then the other, so that the mapping of a disable bit to the wrong leg shows up. During an off period, reversal commands and a dropped enable tell the fast-decay override apart from plain slow decay. A behavioural timing model in the bench is compared with the gates every cycle, which catches an off-by-one in the prescaler, the synchronizer depth or the end-of-period test.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_BLANK = 2'd0,
    PH_DRIVE = 2'd1,
    PH_OFF   = 2'd2
  } chopPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;   // clear prescaler and microsecond counter
    logic latchLen;  // capture the off-time select for a new period
  } chopStrobe_t;

endpackage

// File: rtl/chop_datapath.sv
module chop_datapath
  import chop_pkg::*;
#(
  parameter int TICK_DIV    = 200,
  parameter int OFF_STEP_US = 20,
  parameter int BLANK_US    = 4,
  parameter int LEGS        = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [LEGS-1:0] tripRaw,
  input  logic [LEGS-1:0] regDis,
  input  logic [1:0]      offSel,
  input  chopStrobe_t     strb,
  output logic            tripQual,
  output logic            offDone,
  output logic            blankDone
);

  localparam int PSC_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int US_MAX = OFF_STEP_US * 4;
  localparam int US_W   = $clog2(US_MAX + 1);

  logic [LEGS-1:0]  qualVec;
  logic [PSC_W-1:0] psc;
  logic             tick;
  logic [US_W-1:0]  usCnt;
  logic [US_W-1:0]  offLenUs;

  function automatic logic [US_W-1:0] lenFor(input logic [1:0] sel);
    return US_W'((int'(sel) + 1) * OFF_STEP_US);
  endfunction

  // per half-bridge synchronizer and regulation gating
  for (genvar g = 0; g < LEGS; g++) begin : gLeg
    logic syncA, syncB;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
      end else begin
        syncA <= tripRaw[g];
        syncB <= syncA;
      end
    end
    assign qualVec[g] = syncB & ~regDis[g];
  end

  assign tripQual = |qualVec;

  // microsecond prescaler, restarted at each interval start
  assign tick = (psc == PSC_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                psc <= '0;
    else if (strb.restart || tick) psc <= '0;
    else                      psc <= psc + PSC_W'(1);
  end

  // microsecond counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 usCnt <= '0;
    else if (strb.restart)     usCnt <= '0;
    else if (tick && usCnt != US_W'(US_MAX)) usCnt <= usCnt + US_W'(1);
  end

  // off length held for the running period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              offLenUs <= lenFor(2'b01);
    else if (strb.latchLen) offLenUs <= lenFor(offSel);
  end

  assign offDone   = tick && (usCnt == offLenUs - US_W'(1));
  assign blankDone = tick && (usCnt == US_W'(BLANK_US - 1));

  // R7
  len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.latchLen) |-> $stable(offLenUs));

  // R4
  psc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    psc <= PSC_W'(TICK_DIV - 1));

  if (TICK_DIV > 1) begin : gTickChk
    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
      tick |=> !tick);
  end

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        driveEn,
  input  logic        driveDir,
  input  logic        tripQual,
  input  logic        offDone,
  input  logic        blankDone,
  output chopStrobe_t strb,
  output logic [1:0]  hsOn,
  output logic [1:0]  lsOn,
  output logic        offActive
);

  chopPhase_t phase, phaseNxt;
  logic       entryDir;
  logic       loadDir;
  logic       reverse;

  always_comb begin
    phaseNxt      = phase;
    strb.restart  = 1'b0;
    strb.latchLen = 1'b0;
    loadDir       = 1'b0;
    unique case (phase)
      PH_BLANK: if (blankDone) phaseNxt = PH_DRIVE;
      PH_DRIVE: if (tripQual) begin
        phaseNxt      = PH_OFF;
        strb.restart  = 1'b1;
        strb.latchLen = 1'b1;
        loadDir       = 1'b1;
      end
      PH_OFF: if (offDone) begin
        strb.restart = 1'b1;
        if (tripQual) begin
          phaseNxt      = PH_OFF;
          strb.latchLen = 1'b1;
        end else begin
          phaseNxt = PH_BLANK;
        end
      end
      default: phaseNxt = PH_BLANK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_BLANK;
      entryDir <= 1'b0;
    end else begin
      phase <= phaseNxt;
      if (loadDir) entryDir <= driveDir;
    end
  end

  assign offActive = (phase == PH_OFF);
  assign reverse   = driveEn && (driveDir != entryDir);

  always_comb begin
    if (offActive && !reverse) begin
      hsOn = 2'b11;
      lsOn = 2'b00;
    end else if (driveEn) begin
      hsOn = driveDir ? 2'b10 : 2'b01;
      lsOn = driveDir ? 2'b01 : 2'b10;
    end else begin
      hsOn = 2'b00;
      lsOn = 2'b00;
    end
  end

  // R5
  blank_no_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_BLANK) |=> (phase != PH_OFF));

  // R2
  off_needs_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(offActive) |-> $past(tripQual));

  // R3
  slow_decay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offActive && !driveEn) |-> (hsOn == 2'b11 && lsOn == 2'b00));

  // R9
  entry_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offActive && $past(offActive)) |-> $stable(entryDir));

endmodule

// File: rtl/trip_chopper.sv
module trip_chopper
  import chop_pkg::*;
#(
  parameter int TICK_DIV    = 200,
  parameter int OFF_STEP_US = 20,
  parameter int BLANK_US    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       driveEn,
  input  logic       driveDir,
  input  logic [1:0] tripRaw,
  input  logic [1:0] offSel,
  input  logic [1:0] regDis,
  output logic [1:0] hsOn,
  output logic [1:0] lsOn,
  output logic       offActive
);

  localparam int LEGS = 2;

  chopStrobe_t strb;
  logic        tripQual;
  logic        offDone;
  logic        blankDone;

  chop_datapath #(
    .TICK_DIV   (TICK_DIV),
    .OFF_STEP_US(OFF_STEP_US),
    .BLANK_US   (BLANK_US),
    .LEGS       (LEGS)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .tripRaw  (tripRaw),
    .regDis   (regDis),
    .offSel   (offSel),
    .strb     (strb),
    .tripQual (tripQual),
    .offDone  (offDone),
    .blankDone(blankDone)
  );

  chop_ctrl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .driveEn  (driveEn),
    .driveDir (driveDir),
    .tripQual (tripQual),
    .offDone  (offDone),
    .blankDone(blankDone),
    .strb     (strb),
    .hsOn     (hsOn),
    .lsOn     (lsOn),
    .offActive(offActive)
  );

  // R1
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsOn & lsOn) == 2'b00);

endmodule

// File: tb/trip_chopper_test.sv
`timescale 1ns/1ps
module trip_chopper_test;

  localparam int DIV       = 200;
  localparam int BLANK_CYC = 4 * DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       driveEn = 1'b1;
  logic       driveDir = 1'b0;
  logic [1:0] tripRaw = 2'b00;
  logic [1:0] offSel = 2'b01;
  logic [1:0] regDis = 2'b00;
  logic [1:0] hsOn, lsOn;
  logic       offActive;

  int    nChecks = 0;
  int    nFail = 0;
  string curReq = "R10";

  always #2.5 clk = ~clk;

  trip_chopper #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .driveEn(driveEn), .driveDir(driveDir),
    .tripRaw(tripRaw), .offSel(offSel), .regDis(regDis),
    .hsOn(hsOn), .lsOn(lsOn), .offActive(offActive)
  );

  task automatic chk(input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 blank, 1 drive, 2 off
  int         mPh = 0, mEl = 0, mLen = 0;
  logic       mDir = 1'b0;
  logic [1:0] s1 = 2'b00, s2 = 2'b00;
  logic       mq;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mEl = 0; mDir = 1'b0; s1 = 2'b00; s2 = 2'b00;
    end else begin
      mq = |(s2 & ~regDis);
      case (mPh)
        0: if (mEl == BLANK_CYC - 1) begin mPh = 1; mEl = 0; end
           else mEl++;
        1: if (mq) begin
             mPh = 2; mEl = 0; mDir = driveDir;
             mLen = (int'(offSel) + 1) * 20 * DIV;
           end
        default: if (mEl == mLen - 1) begin
             mEl = 0;
             if (mq) mLen = (int'(offSel) + 1) * 20 * DIV;
             else mPh = 0;
           end else mEl++;
      endcase
      s2 = s1;
      s1 = tripRaw;
    end
  end

  function automatic int expOut();
    logic [1:0] h, l;
    logic off;
    off = (mPh == 2);
    if (off && !(driveEn && driveDir != mDir)) begin h = 2'b11; l = 2'b00; end
    else if (driveEn) begin
      h = driveDir ? 2'b10 : 2'b01;
      l = driveDir ? 2'b01 : 2'b10;
    end else begin h = 2'b00; l = 2'b00; end
    return int'({off, h, l});
  endfunction

  always @(negedge clk) begin
    if (rstN) chk(curReq, "gates vs model", int'({offActive, hsOn, lsOn}), expOut());
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseTrip(input logic [1:0] m, input int hold);
    tripRaw = m;
    cyc(hold);
    tripRaw = 2'b00;
  endtask

  task automatic measureOff(output int len);
    int w;
    w = 0;
    len = 0;
    @(negedge clk);
    while (!offActive && w < 50) begin @(negedge clk); w++; end
    while (offActive && len < 40000) begin @(negedge clk); len++; end
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual 200000 cycles, expected completion earlier");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : stim
    int len;
    cyc(5);
    @(negedge clk);
    chk("R10", "reset gates", int'({offActive, hsOn, lsOn}), int'(5'b0_01_10));
    cyc(1);
    rstN = 1'b1;

    // trip inside the blanking window is ignored
    curReq = "R5";
    cyc(20);
    pulseTrip(2'b01, 100);
    cyc(100);
    @(negedge clk);
    chk("R5", "no off during reset blanking", int'(offActive), 0);
    chk("R10", "gates follow command after reset", int'({hsOn, lsOn}), int'(4'b01_10));
    cyc(BLANK_CYC);

    // latency and slow-decay pattern
    curReq = "R2";
    tripRaw = 2'b01;
    repeat (3) @(negedge clk);
    chk("R2", "offActive before third edge", int'(offActive), 0);
    @(negedge clk);
    chk("R2", "offActive on third edge", int'(offActive), 1);
    chk("R3", "slow decay gates", int'({hsOn, lsOn}), int'(4'b11_00));
    cyc(1);
    tripRaw = 2'b00;
    curReq = "R4";
    cyc(8100);
    @(negedge clk);
    chk("R5", "off ended, drive resumed", int'({offActive, hsOn, lsOn}), int'(5'b0_01_10));
    cyc(100);
    pulseTrip(2'b10, 50);
    cyc(20);
    @(negedge clk);
    chk("R5", "trip in post-off blanking ignored", int'(offActive), 0);
    cyc(BLANK_CYC);

    // held trip chains a second period
    curReq = "R6";
    offSel = 2'b00;
    fork
      measureOff(len);
      begin pulseTrip(2'b01, 4100); end
    join
    chk("R6", "two chained 20us periods", len, 8000);
    cyc(BLANK_CYC + 10);

    // select change mid-period applies to the next period
    curReq = "R7";
    offSel = 2'b11;
    fork
      measureOff(len);
      begin
        tripRaw = 2'b10;
        cyc(1000);
        offSel = 2'b00;
        cyc(16500);
        tripRaw = 2'b00;
      end
    join
    chk("R7", "80us then 20us", len, 20000);
    cyc(BLANK_CYC + 10);

    // regulation disable mapping
    curReq = "R8";
    regDis = 2'b01;
    pulseTrip(2'b01, 200);
    cyc(5);
    @(negedge clk);
    chk("R8", "leg1 disabled ignores leg1 trip", int'(offActive), 0);
    fork
      measureOff(len);
      pulseTrip(2'b10, 50);
    join
    chk("R8", "leg1 disabled, leg2 trip regulates 20us", len, 4000);
    cyc(BLANK_CYC + 10);
    regDis = 2'b10;
    pulseTrip(2'b10, 200);
    cyc(5);
    @(negedge clk);
    chk("R8", "leg2 disabled ignores leg2 trip", int'(offActive), 0);
    regDis = 2'b11;
    cyc(1);
    pulseTrip(2'b11, 200);
    cyc(5);
    @(negedge clk);
    chk("R8", "both disabled ignore trips", int'(offActive), 0);
    regDis = 2'b00;
    cyc(1);

    // direction reversal and enable drop during off
    curReq = "R9";
    offSel = 2'b01;
    fork
      measureOff(len);
      begin
        pulseTrip(2'b01, 20);
        cyc(100);
        driveDir = 1'b1;
        @(negedge clk);
        chk("R9", "reverse drive during off", int'({offActive, hsOn, lsOn}), int'(5'b1_10_01));
        cyc(100);
        driveEn = 1'b0;
        @(negedge clk);
        chk("R3", "enable low during off keeps decay", int'({hsOn, lsOn}), int'(4'b11_00));
        cyc(1);
        driveEn = 1'b1;
        driveDir = 1'b0;
        @(negedge clk);
        chk("R3", "same direction during off decays", int'({hsOn, lsOn}), int'(4'b11_00));
      end
    join
    chk("R9", "reversal leaves 40us timer intact", len, 8000);
    chk("R4", "code 01 gives 40us", len, 40 * DIV);
    cyc(10);

    // plain drive patterns
    curReq = "R1";
    driveDir = 1'b1;
    @(negedge clk);
    chk("R1", "reverse drive pattern", int'({hsOn, lsOn}), int'(4'b10_01));
    cyc(1);
    driveEn = 1'b0;
    @(negedge clk);
    chk("R1", "disabled coast", int'({hsOn, lsOn}), 0);
    cyc(1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule